// File: doc/BRIEF.md
# Cascadable First-Word-Fall-Through Queue

This block is a single-clock queue made of identical first-word-fall-through stages placed in series. Each stage shows its oldest word on its output as soon as the word is settled, without any read. Two active-low flags handle the flow of data. `avail_n` is low while the output shows a valid word. `room_n` is low while the stage can take another word. Between two stages, one stage's output data and `avail_n` feed the next stage's write data and `push_n`, and the next stage's `room_n` feeds back as this stage's `pop_n`. No glue logic is needed. Words drain forward on their own, and free slots travel backward on their own.

A system sees the whole chain as one deep queue. Its capacity is the sum of the stage depths. The first word into an empty chain takes a fixed ripple time to reach the far end. After that, words stream through at one per clock.

The bench builds the chain with default parameters WIDTH=8, DEPTH=8 and STAGES=3. DEPTH must be a power of two.

Top module: `cascade_fifo`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the chain clears. After that edge `avail_n` is 1, `room_n` is 0 and `rd_data` is all zeros.
- R2: A word written into an empty chain appears on `rd_data` with no read. It does so exactly 4*(STAGES-1)+3 rising edges after the edge that accepted it, which is when `avail_n` first reads 0.
- R3: While `avail_n` is 0 and `pop_n` is 1, the next edge keeps `avail_n` at 0 and `rd_data` unchanged.
- R4: `room_n` is 0 only while the chain holds fewer than STAGES*DEPTH words. With no reads, exactly STAGES*DEPTH writes are accepted, after which `room_n` stays 1.
- R5: A write with `push_n`=0 while `room_n`=1 is ignored. Its word never appears on the output, and the count of accepted writes does not change.
- R6: A read with `pop_n`=0 while `avail_n`=1 is ignored. A word written later still comes out intact, and no phantom word is produced.
- R7: Accepted words leave in the order they were accepted, with unchanged values. A read is accepted at an edge where `pop_n`=0 and `avail_n`=0.
- R8: In a full chain, after a single read is accepted at edge R, `room_n` first reads 0 exactly 3*(STAGES-1)+2 edges after R.
- R9: Writes and reads are both held active every cycle from an empty chain. Once the first word has arrived, `avail_n` stays 0 every cycle and every write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared transfer clock for all stages |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_data | input | WIDTH | Word offered to the first stage |
| push_n | input | 1 | Write request, active low |
| room_n | output | 1 | First stage can accept a word, active low |
| rd_data | output | WIDTH | Oldest word, valid while `avail_n` is 0 |
| pop_n | input | 1 | Read request, active low |
| avail_n | output | 1 | Valid word on `rd_data`, active low |

## Verification
The bench builds three stages of eight words each at eight bits wide. This gives a 24-word queue with two interior stage-to-stage hops. It brings into reach the ripple latency of 11 edges and the bubble latency of 8 edges, both of which differ from the single-stage figures. With eight words per stage, the pointer lag inside a stage does not throttle the one-word-per-clock stream. Directed fill, drain, empty-read and over-fill sequences are mixed with a long seeded random run against a queue model.

// File: rtl/cfifo_pkg.sv
// Package: shared polarity constants for the active-low handshake flags.
// Assumes every flag and request in the chain uses the same low-true sense.
package cfifo_pkg;
    localparam logic FLAG_ON  = 1'b0;
    localparam logic FLAG_OFF = 1'b1;
endpackage

// File: rtl/cfifo_store.sv
// Storage array of one stage. Writes happen on the clock edge and reads are
// combinational. Assumes the control logic never writes a slot that the read
// side still counts as occupied.
module cfifo_store #(
    parameter int WIDTH = 8,
    parameter int AW    = 3
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    localparam int SLOTS = 1 << AW;

    logic [WIDTH-1:0] mem [SLOTS];

    // Capture an accepted word into its slot.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/cfifo_wr_ctrl.sv
// Write side of one stage. It owns the write pointer and the room flag. The
// read pointer is seen one cycle late, so freed space shows up on room_n two
// edges after a read. A write that fills the stage raises room_n at once.
module cfifo_wr_ctrl
    import cfifo_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_n,
    input  logic [AW:0] rptr,
    output logic [AW:0] wptr,
    output logic        we,
    output logic        room_n
);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] FULL_CNT = {1'b1, {AW{1'b0}}};

    logic [PW-1:0] rptr_q1;
    logic [PW-1:0] wptr_nxt;

    assign we       = (push_n == FLAG_ON) && (room_n == FLAG_ON);
    assign wptr_nxt = wptr + PW'(we);

    // Advance the write pointer, delay the read pointer, and update room.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr_q1 <= '0;
            room_n  <= FLAG_ON;
        end else begin
            wptr    <= wptr_nxt;
            rptr_q1 <= rptr;
            room_n  <= ((wptr_nxt - rptr_q1) == FULL_CNT) ? FLAG_OFF : FLAG_ON;
        end
    end
endmodule

// File: rtl/cfifo_rd_ctrl.sv
// Read side of one stage. It owns the read pointer, the output register and
// the avail flag. The write pointer passes through two delay registers, so a
// new word shows three edges after its write. A read loads the next word on
// the same edge when one is ready, which keeps streaming gap-free.
module cfifo_rd_ctrl
    import cfifo_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int AW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop_n,
    input  logic [AW:0]      wptr,
    input  logic [WIDTH-1:0] rdata,
    output logic [AW-1:0]    raddr,
    output logic [AW:0]      rptr,
    output logic [WIDTH-1:0] dout,
    output logic             avail_n
);
    localparam int PW = AW + 1;

    logic [PW-1:0] wptr_q1;
    logic [PW-1:0] wptr_q2;
    logic [PW-1:0] rptr_nxt;
    logic          take;
    logic          ready;

    assign take     = (pop_n == FLAG_ON) && (avail_n == FLAG_ON);
    assign rptr_nxt = rptr + PW'(take);
    assign raddr    = rptr_nxt[AW-1:0];
    assign ready    = (wptr_q2 != rptr_nxt);

    // Delay the write pointer, advance the read pointer, present the head word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q1 <= '0;
            wptr_q2 <= '0;
            rptr    <= '0;
            dout    <= '0;
            avail_n <= FLAG_OFF;
        end else begin
            wptr_q1 <= wptr;
            wptr_q2 <= wptr_q1;
            rptr    <= rptr_nxt;
            avail_n <= ready ? FLAG_ON : FLAG_OFF;
            if (ready) dout <= rdata;
        end
    end
endmodule

// File: rtl/cfifo_stage.sv
// One first-word-fall-through stage: storage plus write and read control. Its
// flags have the sense that lets identical stages connect output to input.
module cfifo_stage #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic             push_n,
    output logic             room_n,
    output logic [WIDTH-1:0] dout,
    input  logic             pop_n,
    output logic             avail_n
);
    localparam int AW = $clog2(DEPTH);

    logic [AW:0]      wptr;
    logic [AW:0]      rptr;
    logic             we;
    logic [AW-1:0]    raddr;
    logic [WIDTH-1:0] rdata;

    cfifo_store #(.WIDTH(WIDTH), .AW(AW)) u_store (
        .clk   (clk),
        .we    (we),
        .waddr (wptr[AW-1:0]),
        .wdata (din),
        .raddr (raddr),
        .rdata (rdata)
    );

    cfifo_wr_ctrl #(.AW(AW)) u_wr (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_n (push_n),
        .rptr   (rptr),
        .wptr   (wptr),
        .we     (we),
        .room_n (room_n)
    );

    cfifo_rd_ctrl #(.WIDTH(WIDTH), .AW(AW)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .pop_n   (pop_n),
        .wptr    (wptr),
        .rdata   (rdata),
        .raddr   (raddr),
        .rptr    (rptr),
        .dout    (dout),
        .avail_n (avail_n)
    );
endmodule

// File: rtl/cascade_fifo.sv
// Chain of STAGES identical stages on one clock. Each stage's data and avail
// flag drive the next stage's input and push request. The next stage's room
// flag returns as this stage's pop request. Total depth is STAGES*DEPTH.
module cascade_fifo #(
    parameter int WIDTH  = 8,
    parameter int DEPTH  = 8,
    parameter int STAGES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             push_n,
    output logic             room_n,
    output logic [WIDTH-1:0] rd_data,
    input  logic             pop_n,
    output logic             avail_n
);
    logic [WIDTH-1:0] data_link [STAGES+1];
    logic             push_link [STAGES+1];
    logic             room_link [STAGES+1];

    assign data_link[0]      = wr_data;
    assign push_link[0]      = push_n;
    assign room_link[STAGES] = pop_n;
    assign room_n            = room_link[0];
    assign rd_data           = data_link[STAGES];
    assign avail_n           = push_link[STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        cfifo_stage #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .din     (data_link[s]),
            .push_n  (push_link[s]),
            .room_n  (room_link[s]),
            .dout    (data_link[s+1]),
            .pop_n   (room_link[s+1]),
            .avail_n (push_link[s+1])
        );
    end
endmodule

// File: rtl/cascade_fifo_chk.sv
// Property checker for the chain. It keeps its own occupancy count from the
// accepted handshakes at the ports and checks the flags against that count.
module cascade_fifo_chk #(
    parameter int WIDTH  = 8,
    parameter int DEPTH  = 8,
    parameter int STAGES = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] wr_data,
    input logic             push_n,
    input logic             room_n,
    input logic [WIDTH-1:0] rd_data,
    input logic             pop_n,
    input logic             avail_n
);
    localparam int TOTAL = STAGES * DEPTH;
    localparam int CW    = $clog2(TOTAL + 1) + 1;

    logic [CW-1:0] fill;
    logic          past_ok = 1'b0;
    logic          acc_w;
    logic          acc_r;

    assign acc_w = !push_n && !room_n;
    assign acc_r = !pop_n && !avail_n;

    // Track words held, from accepted writes and reads at the ports.
    always_ff @(posedge clk) begin
        past_ok <= 1'b1;
        if (!rst_n) fill <= '0;
        else        fill <= fill + CW'(acc_w) - CW'(acc_r);
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        past_ok && !$past(rst_n) |-> (avail_n && !room_n && rd_data == '0));

    // R3
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!avail_n && pop_n) |=> (!avail_n && $stable(rd_data)));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(TOTAL));

    // R4
    room_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !room_n |-> fill < CW'(TOTAL));

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !avail_n |-> fill != '0);
endmodule

bind cascade_fifo cascade_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .STAGES(STAGES)) u_chk (.*);

// File: tb/tb_cascade_fifo.sv
module tb_cascade_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int D = 8;
    localparam int N = 3;
    localparam int TOTAL = N * D;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         push_n = 1'b1;
    logic         pop_n = 1'b1;
    logic         room_n;
    logic [W-1:0] rd_data;
    logic         avail_n;

    int errors = 0;
    int checks = 0;
    logic [W-1:0] sb [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cascade_fifo #(.WIDTH(W), .DEPTH(D), .STAGES(N)) dut (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .push_n(push_n),
        .room_n(room_n), .rd_data(rd_data), .pop_n(pop_n), .avail_n(avail_n)
    );

    function automatic int ripple_edges(input int n);
        return 4 * (n - 1) + 3;
    endfunction

    function automatic int bubble_edges(input int n);
        return 3 * (n - 1) + 2;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // One cycle: drive at the falling edge, then score what the next rising edge accepts.
    task automatic cyc(input logic p_n, input logic [W-1:0] d, input logic q_n,
                       output bit wrote, output bit took);
        @(negedge clk);
        push_n  = p_n;
        wr_data = d;
        pop_n   = q_n;
        wrote = !p_n && !room_n;
        took  = !q_n && !avail_n;
        if (took) begin
            if (sb.size() == 0) chk(1'b0, "R6 phantom word", rd_data, 0);
            else begin
                chk(rd_data == sb[0], "R7 order", rd_data, sb[0]);
                void'(sb.pop_front());
            end
        end
        if (wrote) sb.push_back(d);
    endtask

    task automatic idle();
        bit a, b;
        cyc(1'b1, '0, 1'b1, a, b);
    endtask

    task automatic drain();
        bit a, b;
        for (int i = 0; i < 600 && sb.size() > 0; i++) cyc(1'b1, '0, 1'b0, a, b);
        chk(sb.size() == 0, "R7 drain complete", sb.size(), 0);
        repeat (20) idle();
        chk(avail_n == 1'b1, "R6 empty after drain", avail_n, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
    end

    initial begin
        bit a, b;
        int m, acc, gaps, rej;
        bit seen;
        logic [W-1:0] v;
        void'($urandom(32'h5EED1234));

        // R1: reset state while reset is held
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(avail_n == 1'b1, "R1 avail_n", avail_n, 1);
        chk(room_n == 1'b0, "R1 room_n", room_n, 0);
        chk(rd_data == '0, "R1 rd_data", rd_data, 0);
        rst_n = 1'b1;

        // R2: first word ripples down with no read
        cyc(1'b0, 8'hA5, 1'b1, a, b);
        chk(a, "R2 write accepted", a, 1);
        m = 0;
        for (int i = 0; i < 60; i++) begin
            idle();
            if (avail_n == 1'b0) break;
            m++;
        end
        chk(m == ripple_edges(N), "R2 ripple edges", m, ripple_edges(N));
        chk(rd_data == 8'hA5, "R2 word shown", rd_data, 8'hA5);
        // R3: word held while not read
        repeat (3) idle();
        chk(avail_n == 1'b0 && rd_data == 8'hA5, "R3 hold", rd_data, 8'hA5);
        cyc(1'b1, '0, 1'b0, a, b);
        chk(b, "R7 read accepted", b, 1);
        idle();
        chk(avail_n == 1'b1, "R3 empty after last read", avail_n, 1);

        // R6: reads on empty ignored
        repeat (5) cyc(1'b1, '0, 1'b0, a, b);
        cyc(1'b0, 8'h3C, 1'b1, a, b);
        for (int i = 0; i < 40 && avail_n == 1'b1; i++) idle();
        chk(rd_data == 8'h3C, "R6 word after empty reads", rd_data, 8'h3C);
        cyc(1'b1, '0, 1'b0, a, b);
        idle();
        chk(avail_n == 1'b1, "R6 no phantom word", avail_n, 1);

        // R4: fill to total depth with no reads
        acc = 0;
        v = 8'h10;
        for (int i = 0; i < 90; i++) begin
            cyc(1'b0, v, 1'b1, a, b);
            if (a) acc++;
            v++;
        end
        chk(acc == TOTAL, "R4 accepted count", acc, TOTAL);
        chk(room_n == 1'b1, "R4 room_n when full", room_n, 1);
        // R5: writes while full ignored
        for (int i = 0; i < 10; i++) begin
            cyc(1'b0, 8'hEE, 1'b1, a, b);
            if (a) acc++;
        end
        chk(acc == TOTAL, "R5 no extra accepted", acc, TOTAL);

        // R8: one read bubbles space back to the first stage
        cyc(1'b1, '0, 1'b0, a, b);
        chk(b, "R8 read accepted", b, 1);
        m = 0;
        for (int i = 0; i < 60; i++) begin
            idle();
            if (room_n == 1'b0) break;
            m++;
        end
        chk(m == bubble_edges(N), "R8 bubble edges", m, bubble_edges(N));
        drain();

        // R9: continuous streaming from empty
        gaps = 0; rej = 0; seen = 1'b0;
        for (int i = 0; i < 80; i++) begin
            cyc(1'b0, W'($urandom), 1'b0, a, b);
            if (!a) rej++;
            if (avail_n == 1'b0) seen = 1'b1;
            else if (seen) gaps++;
        end
        chk(seen, "R9 stream started", seen, 1);
        chk(gaps == 0, "R9 output gaps", gaps, 0);
        chk(rej == 0, "R9 rejected writes", rej, 0);
        drain();

        // R7: seeded random traffic against the queue model
        for (int i = 0; i < 4000; i++) begin
            cyc(($urandom % 10) >= 6, W'($urandom), ($urandom % 2) == 0, a, b);
        end
        drain();

        summary();
    end
endmodule